// File: doc/BRIEF.md
# Audio Master and Bit Clock Generator

This block builds all serial-audio timing from a single bus clock domain. It takes a source tick from one of two places: every bus clock cycle, or each rising edge of an external codec clock that has been synchronized into the bus domain. A prescaler divides that tick by (factor + 1) to form the master clock. The master clock is a fixed multiple of the sample rate fs: 256, 384 or 512 fs.

The master clock is divided again to make a bit clock of 16, 32, 48 or 64 fs. The bit clock then drives a word clock that toggles once per half frame. The serial engine receives the levels and single-cycle strobes, all in the bus clock domain. The strobes mark master clock ticks, bit clock edges and frame starts.

A small controller with two states gates the dividers. In HALT, every counter is held clear and the live configuration is copied into the active settings on each cycle. HALT goes to RUN on the first cycle in which the live ratio pair is valid. RUN stays in RUN until a frame boundary. At that boundary the live configuration is copied again. RUN goes back to HALT if the copied pair is invalid, and stays in RUN otherwise.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is low, all outputs are 0: bit clock, word clock, strobes, master enable and error flag.
- R2: With bus-clock source (select = 0), `mclk_en_o` pulses once every (div + 1) bus cycles. A div of 0 gives a pulse on every cycle.
- R3: `mclk_o` is high for ceil((div+1)/2) source ticks and low for the rest of each master period. For example, div = 2 gives two ticks high and one tick low.
- R4: The bit clock period is (div+1) × M / B source ticks. M is the master ratio, coded 00 = 256, 01 = 384, 10 = 512. B is the bit ratio, coded 00 = 16, 01 = 32, 10 = 48, 11 = 64.
- R5: `bclk_rise_o` and `bclk_fall_o` are single-cycle strobes. Each is high exactly in the first cycle of the new bit clock level. The bit clock is high for half its period.
- R6: The word clock changes only together with a bit clock falling strobe. It stays high for B/2 bit clock periods.
- R7: `frame_o` pulses for one cycle when the word clock returns to 0, and on each entry into RUN, one cycle after a valid configuration is seen. A frame lasts B bit clock periods.
- R8: Master code 11, or a pair where M is not a multiple of B (256 or 512 with 48), sets `cfg_err_o`. While the error holds, the bit clock, word clock and master enable are stopped.
- R9: Changes to the source, divider or ratio fields while running take effect only at the next frame boundary.
- R10: With external source (select = 1), each rising edge of `ext_clk_i` is one source tick.
- R11: After an error, a valid configuration clears `cfg_err_o` and restarts the clocks with a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External codec clock, asynchronous |
| src_sel_i | input | 1 | Source select, 0 bus clock, 1 external clock |
| div_i | input | 4 | Prescaler factor, divide by value + 1 |
| mratio_i | input | 2 | Master ratio code |
| bratio_i | input | 2 | Bit clock ratio code |
| mclk_en_o | output | 1 | One-cycle strobe per master clock period |
| mclk_o | output | 1 | Master clock phase level |
| bclk_o | output | 1 | Bit clock level |
| bclk_rise_o | output | 1 | Bit clock rising strobe |
| bclk_fall_o | output | 1 | Bit clock falling strobe |
| ws_o | output | 1 | Word clock, 0 for the first half frame |
| frame_o | output | 1 | Frame start strobe |
| cfg_err_o | output | 1 | Invalid ratio configuration |

## Verification
`mclk_en_o` and `mclk_o` are combinational from the prescaler count, so they are valid in the same cycle as their source tick. The bit clock, word clock, all strobes and the error flag are registered, so they change one edge after the master tick that causes them. A valid configuration in HALT gives `frame_o` in the first cycle after the edge that sees it. The bench samples on the falling clock edge. It measures whole intervals between strobes rather than absolute times, so the fixed one-edge delays cancel out. Only the start-up and recovery checks expect an exact latency of one cycle.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    localparam int DIV_W  = 4;
    localparam int MAX_MR = 512;
    localparam int MIN_BR = 16;
    localparam int MAX_BR = 64;
    localparam int HALF_W = $clog2(MAX_MR / MIN_BR / 2);
    localparam int WORD_W = $clog2(MAX_BR / 2);

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_e;

    typedef struct packed {
        logic             src;
        logic [DIV_W-1:0] div;
        logic [1:0]       mr;
        logic [1:0]       br;
    } clk_cfg_t;

    function automatic int mr_fs(input logic [1:0] code);
        case (code)
            2'b00:   return 256;
            2'b01:   return 384;
            2'b10:   return 512;
            default: return 0;
        endcase
    endfunction

    function automatic int br_fs(input logic [1:0] code);
        return 16 * (int'(code) + 1);
    endfunction

    function automatic logic cfg_bad(input logic [1:0] mr, input logic [1:0] br);
        int m;
        m = mr_fs(mr);
        return (m == 0) || ((m % br_fs(br)) != 0);
    endfunction

endpackage

// File: rtl/acg_edge_sync.sv
module acg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/acg_prescaler.sv
module acg_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mclk_en_o,
    output logic             mclk_ph_o
);
    localparam int CW = DIV_W + 1;

    logic [DIV_W-1:0] cnt_q;
    logic [CW-1:0]    total;
    logic [CW-1:0]    hi_len;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (tick_i)     cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + 1'b1;
    end

    // odd totals give the extra tick to the high phase
    assign total     = {1'b0, div_i} + CW'(1);
    assign hi_len    = total - (total >> 1);
    assign mclk_en_o = !clr_i && tick_i && (cnt_q == div_i);
    assign mclk_ph_o = !clr_i && ({1'b0, cnt_q} < hi_len);
endmodule

// File: rtl/acg_bitword.sv
module acg_bitword #(
    parameter int HALF_W = 4,
    parameter int WORD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              mclk_en_i,
    input  logic [HALF_W-1:0] half_m1_i,
    input  logic [WORD_W-1:0] wlast_i,
    output logic              bclk_o,
    output logic              rise_o,
    output logic              fall_o,
    output logic              ws_o,
    output logic              frame_end_o
);
    logic [HALF_W-1:0] bc_cnt_q;
    logic [WORD_W-1:0] bit_cnt_q;
    logic bclk_q, ws_q, rise_q, fall_q;
    logic tgl, fall_evt, wrap;

    assign tgl         = !clr_i && mclk_en_i && (bc_cnt_q == half_m1_i);
    assign fall_evt    = tgl && bclk_q;
    assign wrap        = fall_evt && (bit_cnt_q == wlast_i);
    assign frame_end_o = wrap && ws_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            bc_cnt_q  <= '0;
            bit_cnt_q <= '0;
            bclk_q    <= 1'b0;
            ws_q      <= 1'b0;
            rise_q    <= 1'b0;
            fall_q    <= 1'b0;
        end else begin
            rise_q <= tgl && !bclk_q;
            fall_q <= fall_evt;
            if (mclk_en_i) bc_cnt_q  <= (bc_cnt_q == half_m1_i) ? '0 : bc_cnt_q + 1'b1;
            if (tgl)       bclk_q    <= ~bclk_q;
            if (fall_evt)  bit_cnt_q <= wrap ? '0 : bit_cnt_q + 1'b1;
            if (wrap)      ws_q      <= ~ws_q;
        end
    end

    assign bclk_o = bclk_q;
    assign rise_o = rise_q;
    assign fall_o = fall_q;
    assign ws_o   = ws_q;
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic             src_sel_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       mratio_i,
    input  logic [1:0]       bratio_i,
    output logic             mclk_en_o,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             bclk_rise_o,
    output logic             bclk_fall_o,
    output logic             ws_o,
    output logic             frame_o,
    output logic             cfg_err_o
);
    gen_state_e state_q, state_d;
    clk_cfg_t   act_q;
    logic       err_q, frame_q;
    logic       live_bad, load, clr, ext_rise, tick, frame_end;
    logic [HALF_W-1:0] half_m1;
    logic [WORD_W-1:0] wlast;

    assign live_bad = cfg_bad(mratio_i, bratio_i);
    assign clr      = (state_q == ST_HALT);
    assign load     = clr || frame_end;
    assign tick     = act_q.src ? ext_rise : 1'b1;

    always_comb begin
        int ratio;
        ratio   = mr_fs(act_q.mr) / br_fs(act_q.br);
        half_m1 = (ratio >= 2) ? HALF_W'(ratio / 2 - 1) : '0;
        wlast   = WORD_W'(br_fs(act_q.br) / 2 - 1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (!live_bad)              state_d = ST_RUN;
            ST_RUN:  if (frame_end && live_bad)  state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= '0;
            err_q   <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            frame_q <= load && !live_bad;
            if (load) begin
                act_q <= '{src: src_sel_i, div: div_i, mr: mratio_i, br: bratio_i};
                err_q <= live_bad;
            end
        end
    end

    acg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_clk_i), .rise_o(ext_rise)
    );

    acg_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick), .div_i(act_q.div),
        .mclk_en_o(mclk_en_o), .mclk_ph_o(mclk_o)
    );

    acg_bitword #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_bw (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .mclk_en_i(mclk_en_o),
        .half_m1_i(half_m1), .wlast_i(wlast),
        .bclk_o(bclk_o), .rise_o(bclk_rise_o), .fall_o(bclk_fall_o),
        .ws_o(ws_o), .frame_end_o(frame_end)
    );

    assign frame_o   = frame_q;
    assign cfg_err_o = err_q;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic mclk_en_o,
    input logic bclk_o,
    input logic bclk_rise_o,
    input logic bclk_fall_o,
    input logic ws_o,
    input logic frame_o,
    input logic cfg_err_o
);
    // R5
    rise_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise_o |-> (bclk_o && !$past(bclk_o)));

    // R5
    fall_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall_o |-> (!bclk_o && $past(bclk_o)));

    // R5
    edge_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_o != $past(bclk_o)) |-> (bclk_rise_o || bclk_fall_o));

    // R6
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_o != $past(ws_o)) |-> bclk_fall_o);

    // R7
    frame_ws_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> !ws_o);

    // R8
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!bclk_o && !ws_o && !mclk_en_o && !bclk_rise_o));
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mclk_en_o(mclk_en_o), .bclk_o(bclk_o),
    .bclk_rise_o(bclk_rise_o), .bclk_fall_o(bclk_fall_o), .ws_o(ws_o),
    .frame_o(frame_o), .cfg_err_o(cfg_err_o)
);

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;
    logic clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0, src_sel = 1'b0;
    logic [3:0] div = '0;
    logic [1:0] mr = 2'b00, br = 2'b11;
    logic mclk_en, mclk, bclk, rise, fall, ws, frame, cfg_err;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always #12 ext_clk = ~ext_clk;

    audio_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .src_sel_i(src_sel),
        .div_i(div), .mratio_i(mr), .bratio_i(br),
        .mclk_en_o(mclk_en), .mclk_o(mclk), .bclk_o(bclk),
        .bclk_rise_o(rise), .bclk_fall_o(fall), .ws_o(ws),
        .frame_o(frame), .cfg_err_o(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit hit(input int sel);
        case (sel)
            0: return rise;
            1: return fall;
            2: return frame;
            3: return mclk_en;
            default: return 1'b0;
        endcase
    endfunction

    task automatic wait_ev(input int sel, input int lim, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!hit(sel) && n < lim);
    endtask

    task automatic restart(input logic s, input logic [3:0] d, input logic [1:0] m, input logic [1:0] b);
        @(negedge clk);
        rst_n = 1'b0; src_sel = s; div = d; mr = m; br = b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic period(input int sel, input int lim, output int p);
        int n;
        wait_ev(sel, lim, n);
        wait_ev(sel, lim, p);
    endtask

    task automatic t_reset;
        int n;
        @(negedge clk);
        rst_n = 1'b0; mr = 2'b00; br = 2'b11; div = 4'd0; src_sel = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 outputs in reset", {mclk_en, bclk, rise, fall, ws, frame, cfg_err}, 0);
        rst_n = 1'b1;
        wait_ev(2, 8, n);
        chk("R7 frame strobe on start", n, 1);
    endtask

    task automatic t_mclk;
        int p;
        restart(0, 4'd0, 2'b00, 2'b11); period(3, 100, p); chk("R2 div0 spacing", p, 1);
        restart(0, 4'd5, 2'b00, 2'b11); period(3, 100, p); chk("R2 div5 spacing", p, 6);
        restart(0, 4'd15, 2'b00, 2'b11); period(3, 100, p); chk("R2 div15 spacing", p, 16);
    endtask

    task automatic t_phase;
        int n, hi;
        restart(0, 4'd2, 2'b00, 2'b11);
        wait_ev(3, 100, n);
        hi = 0;
        for (int i = 0; i < 3; i++) begin @(negedge clk); hi += int'(mclk); end
        chk("R3 odd divide high ticks", hi, 2);
        restart(0, 4'd3, 2'b00, 2'b11);
        wait_ev(3, 100, n);
        hi = 0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); hi += int'(mclk); end
        chk("R3 even divide high ticks", hi, 2);
    endtask

    task automatic t_bclk(input logic [3:0] d, input logic [1:0] m, input logic [1:0] b, input int exp);
        int p, h;
        restart(0, d, m, b);
        period(0, 2000, p);
        chk("R4 bit clock period", p, exp);
        wait_ev(1, 2000, h);
        chk("R5 bit clock high width", h, exp / 2);
    endtask

    task automatic t_word;
        int p, n, cnt;
        restart(0, 4'd0, 2'b01, 2'b10);
        period(2, 2000, p);
        chk("R7 frame length 384/48", p, 384);
        chk("R7 word low at frame", int'(ws), 0);
        n = 0;
        while (!ws && n < 2000) begin @(negedge clk); n++; end
        cnt = 0;
        while (ws && n < 4000) begin cnt += int'(fall); @(negedge clk); n++; end
        chk("R6 bit clocks with word high", cnt, 24);
    endtask

    task automatic t_err(input logic [1:0] m, input logic [1:0] b);
        int rises;
        restart(0, 4'd0, m, b);
        rises = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); rises += int'(rise) + int'(bclk) + int'(mclk_en); end
        chk("R8 error flag", int'(cfg_err), 1);
        chk("R8 clocks stopped", rises, 0);
    endtask

    task automatic t_recover;
        int n, p;
        t_err(2'b10, 2'b10);
        mr = 2'b00; br = 2'b11;
        wait_ev(2, 8, n);
        chk("R11 restart frame latency", n, 1);
        chk("R11 error cleared", int'(cfg_err), 0);
        period(0, 200, p);
        chk("R11 clock resumes", p, 4);
    endtask

    task automatic t_boundary;
        int n, p;
        restart(0, 4'd0, 2'b00, 2'b11);
        wait_ev(2, 1000, n);
        repeat (10) @(negedge clk);
        br = 2'b01;
        period(0, 200, p);
        chk("R9 old period kept mid-frame", p, 4);
        wait_ev(2, 1000, n);
        period(0, 200, p);
        chk("R9 new period after boundary", p, 8);
    endtask

    task automatic t_ext;
        int p;
        restart(1, 4'd0, 2'b00, 2'b11);
        period(3, 200, p); chk("R10 ext master spacing", p, 6);
        period(0, 500, p); chk("R10 ext bit clock period", p, 24);
        restart(1, 4'd1, 2'b00, 2'b11);
        period(3, 200, p); chk("R10 ext div1 spacing", p, 12);
    endtask

    initial begin
        t_reset();
        t_mclk();
        t_phase();
        t_bclk(4'd0, 2'b00, 2'b11, 4);
        t_bclk(4'd1, 2'b01, 2'b10, 16);
        t_bclk(4'd0, 2'b10, 2'b01, 16);
        t_bclk(4'd2, 2'b01, 2'b00, 72);
        t_word();
        t_err(2'b00, 2'b10);
        t_err(2'b11, 2'b00);
        t_recover();
        t_boundary();
        t_ext();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule